// File: doc/BRIEF.md
# Dual-Strobe Shift Register

This block is a four-stage shift register, QA through QD, with a single mode input that picks between two kinds of work. In shift mode (mode input low) a pulse on the shift strobe moves the serial input into QA, and every stage takes the value of the stage before it. In load mode (mode input high) a pulse on the load strobe copies the four parallel inputs into the four stages in one step. A pulse on the strobe that the current mode does not select is ignored.

All activity happens in one clock domain, and the two strobes act as clock enables. These two modes cover four uses: serial in with parallel out, serial in with serial out, parallel in with parallel out, and parallel in with serial out. QD is also driven on a separate serial output.

The register can also shift left. A left-shift enable, used in load mode, replaces the parallel inputs with the register's own outputs so that the shift runs the other way. This wiring is inside the block. During a left shift, data enters at QD and moves toward QA.

Top module: `dual_strobe_shreg`

## Requirements
- R1: When the synchronous reset is high at a clock edge, all stages become 0, whatever the other inputs are.
- R2: With `mode_load`=0 and `shift_stb`=1 at a clock edge, the next values are: QA takes `ser_in`, QB takes QA, QC takes QB and QD takes QC. `stages` bit 0 is QA and bit 3 is QD.
- R3: With `mode_load`=1, `load_stb`=1 and `left_en`=0 at a clock edge, `par_in` bit i is copied into `stages` bit i (bit 0 is input A and goes to QA; bit 3 is input D and goes to QD).
- R4: `ser_out` always equals QD. After four right shifts, the first bit shifted in is on `ser_out`, and each further shift brings out the next bit in the order the bits entered.
- R5: After a parallel load, setting `mode_load` to 0 and applying shift pulses makes `ser_out` show D, then C, then B, then A.
- R6: With `mode_load`=1, `load_stb`=1 and `left_en`=1 at a clock edge, the next values are: QA takes QB, QB takes QC, QC takes QD and QD takes `ser_in`. After four such pulses, the first bit entered is in QA and the last bit entered is in QD.
- R7: The strobe that the mode does not select has no effect. `load_stb` is ignored when `mode_load`=0, and `shift_stb` is ignored when `mode_load`=1. With no selected strobe, the stages hold their values.
- R8: `left_en` has no effect when `mode_load`=0. A shift pulse still performs the R2 shift.
- R9: When both strobes are high in the same cycle, only the strobe selected by `mode_load` acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_load | input | 1 | 0 selects the shift strobe, 1 selects the load strobe |
| shift_stb | input | 1 | Shift enable, used in shift mode |
| load_stb | input | 1 | Load enable, used in load mode |
| left_en | input | 1 | In load mode, use the register's own outputs in place of `par_in` to shift left |
| ser_in | input | 1 | Serial data input (enters QA on a right shift, QD on a left shift) |
| par_in | input | 4 | Parallel inputs; bit 0 is A, bit 3 is D |
| stages | output | 4 | Stage outputs; bit 0 is QA, bit 3 is QD |
| ser_out | output | 1 | Serial output, equal to QD |

## Verification
The hardest case to reach from the ports is a strobe that the mode does not select arriving while the data inputs differ from the stored word. This includes the case where both strobes are high together. If the data inputs matched the stored word, a register that wrongly reacted to such a strobe would look correct. The stimulus therefore drives `par_in`, `ser_in` and `left_en` to values that would change the stored word. It also leaves a known pattern in the register before each of these cycles, so that any wrong reaction shows up on `stages`. Mode changes between a load and the shift-out that follows are also driven one cycle after another, with no idle cycle between them.

// File: rtl/dss_pkg.sv
package dss_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_RIGHT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_LEFT  = 2'd3
    } dss_act_e;

endpackage

// File: rtl/dss_strobe_decode.sv
module dss_strobe_decode
    import dss_pkg::*;
(
    input  logic     mode_load,
    input  logic     shift_stb,
    input  logic     load_stb,
    input  logic     left_en,
    output dss_act_e act
);

    always_comb begin
        act = ACT_HOLD;
        if (mode_load) begin
            if (load_stb) begin
                act = left_en ? ACT_LEFT : ACT_LOAD;
            end
        end else begin
            if (shift_stb) begin
                act = ACT_RIGHT;
            end
        end
    end

endmodule

// File: rtl/dss_stage_mux.sv
module dss_stage_mux
    import dss_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  dss_act_e           act,
    input  logic               ser_in,
    input  logic [WIDTH-1:0]   par_in,
    input  logic [WIDTH-1:0]   cur,
    output logic [WIDTH-1:0]   nxt
);

    localparam int LAST = WIDTH - 1;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        logic from_below;
        logic from_above;

        if (i == 0) begin : g_first
            assign from_below = ser_in;
        end else begin : g_rest
            assign from_below = cur[i-1];
        end

        if (i == LAST) begin : g_top
            assign from_above = ser_in;
        end else begin : g_inner
            assign from_above = cur[i+1];
        end

        always_comb begin
            case (act)
                ACT_RIGHT: nxt[i] = from_below;
                ACT_LOAD:  nxt[i] = par_in[i];
                ACT_LEFT:  nxt[i] = from_above;
                default:   nxt[i] = cur[i];
            endcase
        end
    end

endmodule

// File: rtl/dual_strobe_shreg.sv
module dual_strobe_shreg
    import dss_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_load,
    input  logic             shift_stb,
    input  logic             load_stb,
    input  logic             left_en,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] stages,
    output logic             ser_out
);

    localparam int LAST = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] stages;
    } shreg_state_t;

    shreg_state_t st_d, st_q;
    dss_act_e     act;
    logic [WIDTH-1:0] mux_nxt;

    dss_strobe_decode i_decode (
        .mode_load (mode_load),
        .shift_stb (shift_stb),
        .load_stb  (load_stb),
        .left_en   (left_en),
        .act       (act)
    );

    dss_stage_mux #(.WIDTH(WIDTH)) i_mux (
        .act    (act),
        .ser_in (ser_in),
        .par_in (par_in),
        .cur    (st_q.stages),
        .nxt    (mux_nxt)
    );

    always_comb begin
        st_d        = st_q;
        st_d.stages = mux_nxt;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign stages  = st_q.stages;
    assign ser_out = st_q.stages[LAST];

    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (stages == '0));

    // R2, R8
    a_r2_right_shift: assert property (@(posedge clk) disable iff (rst)
        (!mode_load && shift_stb) |=>
            (stages == {$past(stages[WIDTH-2:0]), $past(ser_in)}));

    // R3
    a_r3_parallel_load: assert property (@(posedge clk) disable iff (rst)
        (mode_load && load_stb && !left_en) |=> (stages == $past(par_in)));

    // R6
    a_r6_left_shift: assert property (@(posedge clk) disable iff (rst)
        (mode_load && load_stb && left_en) |=>
            (stages == {$past(ser_in), $past(stages[WIDTH-1:1])}));

    // R7
    a_r7_unselected_holds: assert property (@(posedge clk) disable iff (rst)
        ((!mode_load && !shift_stb) || (mode_load && !load_stb)) |=>
            $stable(stages));

endmodule

// File: tb/test_dual_strobe_shreg.sv
module test_dual_strobe_shreg;

    localparam int W     = 4;
    localparam int CLK_P = 10;

    typedef struct {
        logic [W-1:0] st;
        logic         so;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mode_load = 1'b0;
    logic         shift_stb = 1'b0;
    logic         load_stb = 1'b0;
    logic         left_en = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] stages;
    logic         ser_out;

    exp_t   sb[$];
    logic [W-1:0] mdl = '0;
    int     n_checks = 0;
    int     n_fail = 0;
    bit     done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dual_strobe_shreg #(.WIDTH(W)) i_dual_strobe_shreg (
        .clk       (clk),
        .rst       (rst),
        .mode_load (mode_load),
        .shift_stb (shift_stb),
        .load_stb  (load_stb),
        .left_en   (left_en),
        .ser_in    (ser_in),
        .par_in    (par_in),
        .stages    (stages),
        .ser_out   (ser_out)
    );

    task automatic step(input logic r, input logic m, input logic ss,
                        input logic ls, input logic le, input logic si,
                        input logic [W-1:0] pi, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; mode_load = m; shift_stb = ss; load_stb = ls;
        left_en = le; ser_in = si; par_in = pi;
        if (r)               mdl = '0;
        else if (!m && ss)   mdl = {mdl[W-2:0], si};
        else if (m && ls)    mdl = le ? {si, mdl[W-1:1]} : pi;
        e.st = mdl; e.so = mdl[W-1]; e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
    endtask

    // monitor: pops one expected item per clock after the edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (stages !== e.st || ser_out !== e.so) begin
                    n_fail++;
                    $display("FAIL %s: stages=%b ser_out=%b expected stages=%b ser_out=%b",
                             e.tag, stages, ser_out, e.st, e.so);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset
        step(1, 0, 0, 0, 0, 0, 4'h0, "R1");
        step(1, 1, 1, 1, 0, 1, 4'hF, "R1");

        // R2 serial in, parallel out: 1,0,1,1
        step(0, 0, 1, 0, 0, 1, 4'h0, "R2");
        step(0, 0, 1, 0, 0, 0, 4'h0, "R2");
        step(0, 0, 1, 0, 0, 1, 4'h0, "R2");
        step(0, 0, 1, 0, 0, 1, 4'h0, "R2");

        // R4 serial in, serial out: bits 0,1,1,0 then four more pulses
        step(0, 0, 1, 0, 0, 0, 4'h0, "R4");
        step(0, 0, 1, 0, 0, 1, 4'h0, "R4");
        step(0, 0, 1, 0, 0, 1, 4'h0, "R4");
        step(0, 0, 1, 0, 0, 0, 4'h0, "R4");
        for (int k = 0; k < 4; k++) step(0, 0, 1, 0, 0, 1, 4'h0, "R4");

        // R3 parallel loads
        step(0, 1, 0, 1, 0, 0, 4'b1010, "R3");
        step(0, 1, 0, 1, 0, 1, 4'b0101, "R3");
        step(0, 1, 0, 1, 0, 0, 4'b1100, "R3");

        // R5 parallel in, serial out
        step(0, 1, 0, 1, 0, 0, 4'b0110, "R5");
        for (int k = 0; k < 4; k++) step(0, 0, 1, 0, 0, 0, 4'h0, "R5");

        // R7 unselected strobes ignored, data inputs differ from stored word
        step(0, 1, 0, 1, 0, 0, 4'b1001, "R7");
        step(0, 0, 0, 1, 0, 1, 4'b0110, "R7");
        step(0, 1, 1, 0, 0, 0, 4'b0110, "R7");
        step(0, 1, 1, 0, 1, 1, 4'b1111, "R7");
        step(0, 0, 0, 0, 1, 1, 4'b0000, "R7");

        // R8 left_en ignored in shift mode
        step(0, 0, 1, 0, 1, 1, 4'h0, "R8");
        step(0, 0, 1, 0, 1, 0, 4'hF, "R8");

        // R6 left shift: 1,1,0,1 entered at QD
        step(0, 1, 0, 1, 1, 1, 4'h0, "R6");
        step(0, 1, 0, 1, 1, 1, 4'h0, "R6");
        step(0, 1, 0, 1, 1, 0, 4'h0, "R6");
        step(0, 1, 0, 1, 1, 1, 4'h0, "R6");

        // R9 both strobes together
        step(0, 1, 1, 1, 0, 0, 4'b0011, "R9");
        step(0, 0, 1, 1, 0, 1, 4'b1100, "R9");
        step(0, 1, 1, 1, 1, 0, 4'b1111, "R9");

        // R1 reset during activity
        step(1, 0, 1, 1, 1, 1, 4'hF, "R1");

        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule